// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler with Staggered Banks

This block keeps an SDRAM array with several physical banks refreshed. A programmable countdown marks each refresh deadline and raises a request toward the main access arbiter. The arbiter stops starting new accesses while the request is up. The block waits until the arbiter reports that no access is in flight. It then takes the command bus, closes every open row with one precharge-all command, and waits a programmable precharge-to-activate time. After that it sends one auto-refresh command to each physical bank, one bank per clock, so the banks never draw refresh current at the same moment.

After its own refresh command, each bank has an activation lockout output. The lockout stays high until a programmable recovery count has run out. The deadline grid does not move when a refresh has to wait. If a deadline passes while the previous refresh is still waiting, the block remembers one missed refresh and runs an extra sequence afterwards. A zero interval switches refresh generation off.

Software sizes the interval below: per-row refresh time, minus the longest access that can hold off a refresh, minus the precharge time, minus four clocks. For example, a 15.6 µs row time at 66 MHz is about 1030 clocks. With a 213-clock slow-ROM burst and a 2-clock precharge, the limit is 811, so 810 is programmed.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and straight after reset, every command output is high (NOP: all chip selects, RAS, CAS and WE inactive), and ref_req, ref_busy and act_block are all low.
- R2: With a nonzero interval I and acc_busy held low, precharge-all commands recur exactly every I clocks. Precharge-all is all chip selects low with RAS=0, CAS=1, WE=0.
- R3: An interval of zero produces no refresh request and no command.
- R4: While acc_busy is high, no refresh sequence starts and ref_req stays high. The precharge-all comes in the clock after the first clock in which acc_busy is low.
- R5: The deadline grid does not drift. A deferred refresh does not shift the next precharge-all, which still comes I clocks after the previous undeferred one.
- R6: The first refresh command follows the precharge-all by exactly max(P,1) clocks, where P is cfg_pre_to_act.
- R7: Refresh commands (RAS=0, CAS=0, WE=1) go to banks 0 to N-1 in consecutive clocks. Bank b comes b clocks after bank 0, and exactly one chip select is low in each refresh clock.
- R8: act_block[b] first goes low max(R, N-b) clocks after bank b's refresh command, where R>=1 is cfg_ref_rec and N is the number of banks.
- R9: A deadline that passes while a refresh is still pending adds one extra sequence. Its precharge-all comes max(R,1)+1 clocks after the last bank refresh of the previous sequence. Further missed deadlines are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | CNT_W | Clocks between refresh deadlines; 0 disables |
| cfg_pre_to_act | input | PRE_W | Clocks from precharge-all to first refresh |
| cfg_ref_rec | input | REC_W | Clocks from a bank's refresh until it may be activated |
| acc_busy | input | 1 | Arbiter has a memory access in flight |
| ref_req | output | 1 | A refresh is pending; arbiter must start no new access |
| ref_busy | output | 1 | Refresh sequence owns the command bus |
| act_block | output | NUM_BANKS | Per-bank row-activation lockout |
| cs_n | output | NUM_BANKS | Per-bank chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is a deadline that passes while an earlier refresh is still held off. It is followed by a third deadline that must be dropped. Both are only visible as the spacing of later commands. The bench holds acc_busy high over three deadlines and then releases it. It then checks the positions of the pending sequence, the single extra sequence and the next on-grid sequence. A shorter hold across one deadline checks that the deferred start and the undeferred grid both land in their computed clocks.

// File: rtl/sdram_ref_pkg.sv
package sdram_ref_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_WAIT, ST_REF} seq_state_t;

   // {ras_n, cas_n, we_n}
   localparam logic [2:0] PINS_NOP  = 3'b111;
   localparam logic [2:0] PINS_PALL = 3'b010;
   localparam logic [2:0] PINS_REF  = 3'b001;
endpackage

// File: rtl/sdram_ref_interval.sv
module sdram_ref_interval #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_interval,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;

   // reload on expiry, independent of when the refresh actually runs
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (cfg_interval == '0)
         cnt <= '0;
      else if (cnt <= CNT_W'(1))
         cnt <= cfg_interval;
      else
         cnt <= cnt - 1'b1;
   end

   assign tick = (cfg_interval != '0) && (cnt == CNT_W'(1));
endmodule

// File: rtl/sdram_ref_pending.sv
module sdram_ref_pending #(
   parameter int PEND_MAX = 2,
   localparam int PEND_W = $clog2(PEND_MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic done,
   output logic pending
);
   logic [PEND_W-1:0] pend;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend <= '0;
      else if (tick && !done) begin
         if (pend != PEND_W'(PEND_MAX))
            pend <= pend + 1'b1;
      end else if (done && !tick && pend != '0)
         pend <= pend - 1'b1;
   end

   assign pending = (pend != '0);
endmodule

// File: rtl/sdram_ref_seq.sv
module sdram_ref_seq
   import sdram_ref_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int PRE_W     = 4,
   localparam int IDX_W    = $clog2(NUM_BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pending,
   input  logic             acc_busy,
   input  logic             rec_clear,
   input  logic [PRE_W-1:0] cfg_pre_to_act,
   output logic             busy,
   output logic             pall,
   output logic             done,
   output logic [NUM_BANKS-1:0] ref_onehot
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_BANKS - 1);

   seq_state_t       state;
   logic [PRE_W-1:0] wcnt;
   logic [IDX_W-1:0] bidx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         wcnt  <= '0;
         bidx  <= '0;
      end else begin
         case (state)
            ST_IDLE:
               if (pending && !acc_busy && rec_clear)
                  state <= ST_PRE;
            ST_PRE:
               if (cfg_pre_to_act <= PRE_W'(1)) begin
                  state <= ST_REF;
                  bidx  <= '0;
               end else begin
                  state <= ST_WAIT;
                  wcnt  <= cfg_pre_to_act - PRE_W'(2);
               end
            ST_WAIT:
               if (wcnt == '0) begin
                  state <= ST_REF;
                  bidx  <= '0;
               end else
                  wcnt <= wcnt - 1'b1;
            ST_REF:
               if (bidx == LAST)
                  state <= ST_IDLE;
               else
                  bidx <= bidx + 1'b1;
            default:
               state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign pall = (state == ST_PRE);
   assign done = (state == ST_REF) && (bidx == LAST);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
      assign ref_onehot[b] = (state == ST_REF) && (bidx == IDX_W'(b));
   end
endmodule

// File: rtl/sdram_ref_recovery.sv
module sdram_ref_recovery #(
   parameter int NUM_BANKS = 4,
   parameter int REC_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] ref_onehot,
   input  logic [REC_W-1:0]     cfg_ref_rec,
   output logic [NUM_BANKS-1:0] blocked,
   output logic                 all_clear
);
   logic [REC_W-1:0] load_val;
   assign load_val = (cfg_ref_rec == '0) ? '0 : cfg_ref_rec - 1'b1;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [REC_W-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (ref_onehot[b])
            cnt <= load_val;
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign blocked[b] = (cnt != '0);
   end

   assign all_clear = ~|blocked;
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import sdram_ref_pkg::*;
#(
   parameter int NUM_BANKS  = 4,
   parameter int CNT_W      = 14,
   parameter int PRE_W      = 4,
   parameter int REC_W      = 6,
   parameter int MISS_DEPTH = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [CNT_W-1:0]     cfg_interval,
   input  logic [PRE_W-1:0]     cfg_pre_to_act,
   input  logic [REC_W-1:0]     cfg_ref_rec,
   input  logic                 acc_busy,
   output logic                 ref_req,
   output logic                 ref_busy,
   output logic [NUM_BANKS-1:0] act_block,
   output logic [NUM_BANKS-1:0] cs_n,
   output logic                 ras_n,
   output logic                 cas_n,
   output logic                 we_n
);
   localparam int PEND_MAX = 1 + MISS_DEPTH;

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("sdram_refresh_sched: NUM_BANKS must be at least 2");
   end
   if (CNT_W < 2 || PRE_W < 2 || REC_W < 1) begin : g_bad_widths
      $error("sdram_refresh_sched: counter widths too small");
   end
   if (MISS_DEPTH < 0) begin : g_bad_miss
      $error("sdram_refresh_sched: MISS_DEPTH must be non-negative");
   end

   logic tick, pending, pall, done, rec_clear;
   logic [NUM_BANKS-1:0] ref_onehot, blocked;

   sdram_ref_interval #(.CNT_W(CNT_W)) u_interval (
      .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .tick(tick)
   );

   sdram_ref_pending #(.PEND_MAX(PEND_MAX)) u_pending (
      .clk(clk), .rst_n(rst_n), .tick(tick), .done(done), .pending(pending)
   );

   sdram_ref_seq #(.NUM_BANKS(NUM_BANKS), .PRE_W(PRE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .pending(pending), .acc_busy(acc_busy),
      .rec_clear(rec_clear), .cfg_pre_to_act(cfg_pre_to_act),
      .busy(ref_busy), .pall(pall), .done(done), .ref_onehot(ref_onehot)
   );

   sdram_ref_recovery #(.NUM_BANKS(NUM_BANKS), .REC_W(REC_W)) u_recovery (
      .clk(clk), .rst_n(rst_n), .ref_onehot(ref_onehot),
      .cfg_ref_rec(cfg_ref_rec), .blocked(blocked), .all_clear(rec_clear)
   );

   logic [2:0] pins;
   always_comb begin
      if (pall) begin
         cs_n = '0;
         pins = PINS_PALL;
      end else if (|ref_onehot) begin
         cs_n = ~ref_onehot;
         pins = PINS_REF;
      end else begin
         cs_n = '1;
         pins = PINS_NOP;
      end
   end

   assign {ras_n, cas_n, we_n} = pins;
   assign ref_req   = pending;
   assign act_block = {NUM_BANKS{ref_busy}} | blocked;
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
   parameter int NUM_BANKS = 4,
   parameter int PRE_W     = 4,
   parameter int REC_W     = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [PRE_W-1:0]     cfg_pre_to_act,
   input logic [REC_W-1:0]     cfg_ref_rec,
   input logic                 acc_busy,
   input logic                 ref_req,
   input logic                 ref_busy,
   input logic [NUM_BANKS-1:0] act_block,
   input logic [NUM_BANKS-1:0] cs_n,
   input logic                 ras_n,
   input logic                 cas_n,
   input logic                 we_n
);
   logic is_ref, is_pall;
   assign is_ref  = !ras_n && !cas_n && we_n;
   assign is_pall = !ras_n && cas_n && !we_n;

   a_r7_single_bank_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> $countones(~cs_n) == 1);

   a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_busy) |-> ($past(!acc_busy) && $past(ref_req)));

   a_r6_precharge_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pall && cfg_pre_to_act >= PRE_W'(2)) |=> !is_ref);

   a_r8_lock_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ref && cfg_ref_rec >= REC_W'(2)) |=>
         ((act_block & ~$past(cs_n)) == ~$past(cs_n)));

   a_r1_commands_only_owned: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> ref_busy);
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
   .NUM_BANKS(NUM_BANKS), .PRE_W(PRE_W), .REC_W(REC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_pre_to_act(cfg_pre_to_act),
   .cfg_ref_rec(cfg_ref_rec), .acc_busy(acc_busy), .ref_req(ref_req),
   .ref_busy(ref_busy), .act_block(act_block), .cs_n(cs_n),
   .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
);

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb;
   localparam int NB = 4;
   localparam int CW = 8;
   localparam int PW = 3;
   localparam int RW = 4;

   logic clk = 0;
   logic rst_n = 0;
   logic [CW-1:0] cfg_interval = '0;
   logic [PW-1:0] cfg_pre_to_act = '0;
   logic [RW-1:0] cfg_ref_rec = '0;
   logic acc_busy = 0;
   logic ref_req, ref_busy, ras_n, cas_n, we_n;
   logic [NB-1:0] act_block, cs_n;

   always #2.5 clk = ~clk;

   sdram_refresh_sched #(.NUM_BANKS(NB), .CNT_W(CW), .PRE_W(PW), .REC_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
      .cfg_pre_to_act(cfg_pre_to_act), .cfg_ref_rec(cfg_ref_rec),
      .acc_busy(acc_busy), .ref_req(ref_req), .ref_busy(ref_busy),
      .act_block(act_block), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0, bad = 0;
   bit finished = 0;

   int pre_t[64];
   int pre_n;
   int ref_t[NB][64];
   int free_t[NB][64];
   int ref_n[NB];
   bit watch[NB];
   int multi_bad;

   task automatic clear_log();
      pre_n = 0;
      multi_bad = 0;
      for (int b = 0; b < NB; b++) begin
         ref_n[b] = 0;
         watch[b] = 0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         for (int b = 0; b < NB; b++)
            if (watch[b] && !act_block[b]) begin
               free_t[b][ref_n[b]-1] = cyc;
               watch[b] = 0;
            end
         if (!ras_n && cas_n && !we_n && cs_n == '0 && pre_n < 64) begin
            pre_t[pre_n] = cyc;
            pre_n++;
         end
         if (!ras_n && !cas_n && we_n) begin
            if ($countones(~cs_n) != 1) multi_bad++;
            for (int b = 0; b < NB; b++)
               if (!cs_n[b] && ref_n[b] < 64) begin
                  ref_t[b][ref_n[b]] = cyc;
                  ref_n[b]++;
                  watch[b] = 1;
               end
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic wait_to(int c);
      while (cyc != c) @(negedge clk);
   endtask

   task automatic start(int iv, int p, int rc);
      @(negedge clk);
      rst_n = 0;
      acc_busy = 0;
      cfg_interval = CW'(iv);
      cfg_pre_to_act = PW'(p);
      cfg_ref_rec = RW'(rc);
      repeat (3) @(negedge clk);
      clear_log();
      rst_n = 1;
   endtask

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   initial begin
      int ivs[2] = '{24, 31};
      int ps[5]  = '{0, 1, 2, 3, 5};
      int rcs[2] = '{4, 6};
      int p0;

      // R1: reset state
      cfg_interval = CW'(10);
      repeat (3) @(negedge clk);
      chk("R1 cs_n", int'(cs_n), (1 << NB) - 1);
      chk("R1 ras/cas/we", int'({ras_n, cas_n, we_n}), 7);
      chk("R1 ref_req", int'(ref_req), 0);
      chk("R1 ref_busy", int'(ref_busy), 0);
      chk("R1 act_block", int'(act_block), 0);

      // sweep: R2 period, R6 precharge gap, R7 stagger, R8 recovery
      foreach (ivs[i]) foreach (ps[j]) foreach (rcs[k]) begin
         start(ivs[i], ps[j], rcs[k]);
         repeat (4 * ivs[i] + 10) @(negedge clk);
         chk("R2 count", int'(pre_n >= 3), 1);
         if (pre_n >= 3) begin
            chk("R2 period a", pre_t[1] - pre_t[0], ivs[i]);
            chk("R2 period b", pre_t[2] - pre_t[1], ivs[i]);
         end
         chk("R6 first refresh", ref_t[0][0] - pre_t[0], imax(ps[j], 1));
         for (int b = 1; b < NB; b++)
            chk("R7 stagger", ref_t[b][0] - ref_t[0][0], b);
         chk("R7 single select", multi_bad, 0);
         for (int b = 0; b < NB; b++)
            chk("R8 recovery", free_t[b][0] - ref_t[b][0], imax(rcs[k], NB - b));
      end

      // R3: zero interval
      start(0, 2, 4);
      repeat (300) @(negedge clk);
      chk("R3 no precharge", pre_n, 0);
      chk("R3 no refresh", ref_n[0], 0);
      chk("R3 no request", int'(ref_req), 0);

      // R4/R5: defer one refresh, grid kept
      start(30, 2, 5);
      while (pre_n == 0) @(negedge clk);
      p0 = pre_t[0];
      wait_to(p0 + 27);
      acc_busy = 1;
      wait_to(p0 + 33);
      chk("R4 request held", int'(ref_req), 1);
      chk("R4 bus not taken", int'(ref_busy), 0);
      wait_to(p0 + 36);
      acc_busy = 0;
      chk("R4 no early start", pre_n, 1);
      wait_to(p0 + 65);
      chk("R4 deferred start", pre_t[1], p0 + 37);
      chk("R5 grid kept", pre_t[2], p0 + 60);

      // R9: missed deadline yields one extra sequence, third dropped
      start(20, 1, 3);
      while (pre_n == 0) @(negedge clk);
      p0 = pre_t[0];
      wait_to(p0 + 15);
      acc_busy = 1;
      wait_to(p0 + 62);
      acc_busy = 0;
      wait_to(p0 + 85);
      chk("R9 pending start", pre_t[1], p0 + 63);
      chk("R9 last bank ref", ref_t[NB-1][1], p0 + 67);
      chk("R9 extra sequence", pre_t[2], p0 + 67 + 3 + 1);
      chk("R9 third dropped", pre_t[3], p0 + 80);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule